// File: doc/BRIEF.md
# I2C Master Bus Transaction Engine

This block is the bus-facing half of an I2C master. A register front end supplies a target address, a direction mode, a read length and a bit-rate divider, then pulses `start`. The engine drives SCL and SDA as open-drain lines: each output only pulls its wire low or lets it go. It issues a START condition, sends the address, moves data bytes and ends with a STOP condition. It then reports one of three outcomes: success, no acknowledge on an address byte, or no acknowledge on a data byte.

Outgoing bytes are taken from a show-ahead transmit queue outside the block, through `tx_avail`, `tx_data` and `tx_pop`. Incoming bytes are handed to a receive queue as one-cycle `rx_push` strobes. The addressing width is chosen from the address itself. A combined mode sends the queued bytes and then turns the bus around with a repeated START to read. The divider fixes the SCL period in system clocks. Clock stretching, arbitration between masters and target operation are not part of this block.

Top module: `i2c_xfer_engine`

## Requirements
- R1: After reset and whenever `busy` is low, both `scl_lo` and `sda_lo` are 0 (lines released) and no result strobe is raised.
- R2: Every SCL period during a transaction lasts `div`+1 clock cycles. `div` must be at least 4.
- R3: When `dev_addr[9:7]` is zero, the address is one byte `{dev_addr[6:0], rw}`, where rw=1 means read.
- R4: When `dev_addr[9:7]` is nonzero, the header byte is `{5'b11110, dev_addr[9:8], rw}` and is followed by `dev_addr[7:0]`. A 10-bit read sends the header with rw=0 and the low byte, then a repeated START and the header with rw=1.
- R5: Write mode (`rd_mode`=0, `comb_mode`=0) sends every byte the transmit queue holds, popping each once with `tx_pop`, then a STOP and a `done` strobe. `tx_pop` is raised only while `tx_avail` is high.
- R6: Read mode (`rd_mode`=1, `comb_mode`=0) receives exactly `rd_count`+1 bytes, MSB first, each presented on `rx_data` with one `rx_push` strobe. The master acknowledges every byte except the last, which it leaves unacknowledged before the STOP.
- R7: Combined mode (`comb_mode`=1) sends the write address and all queued bytes, then a repeated START, the address with rw=1, and `rd_count`+1 read bytes.
- R8: A missing acknowledge on any address byte ends the transaction with a STOP and a `nak_addr` strobe. No data byte is sent.
- R9: A missing acknowledge on a sent data byte ends the transaction with a STOP and a `nak_data` strobe. Bytes still queued stay unpopped.
- R10: Each transaction raises exactly one of `done`, `nak_addr`, `nak_data` for one cycle: the first cycle in which `busy` is low again.
- R11: `start` is ignored while `busy` is high. It is accepted in any cycle with `busy` low, including the cycle of a result strobe.
- R12: SDA changes only while SCL is held low, except at a START, a repeated START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (sampled while idle) |
| rd_mode | input | 1 | 1 = read transfer |
| comb_mode | input | 1 | 1 = write queued bytes then read after repeated START |
| dev_addr | input | 10 | Target address; upper three bits nonzero selects 10-bit form |
| rd_count | input | CNTW | Number of bytes to read, minus one |
| div | input | DIVW | SCL period in clocks, minus one |
| tx_avail | input | 1 | Transmit queue holds a byte |
| tx_data | input | 8 | Head of transmit queue |
| tx_pop | output | 1 | Consume the head of the transmit queue |
| rx_push | output | 1 | `rx_data` holds a received byte |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Transaction ended successfully |
| nak_addr | output | 1 | Transaction ended on an address not acknowledged |
| nak_data | output | 1 | Transaction ended on a data byte not acknowledged |
| sda_in | input | 1 | Sensed level of the SDA wire |
| scl_lo | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_lo | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The result strobe of one transaction and the acceptance of the next `start` can fall in the same cycle, because `busy` drops on the very edge that raises the strobe. The bench waits for a strobe and, in that same cycle, drives a read request. It then checks that `busy` is high one cycle later and that the second transaction's START, address byte, NAK bit and STOP follow the first transaction's STOP on the wire in order. Just before this, a `start` pulse in the middle of a transaction must leave the wire sequence unchanged.

// File: rtl/i2c_xfer_engine.sv
module i2c_xfer_engine #(
  parameter int DIVW = 16,
  parameter int CNTW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rd_mode,
  input  logic            comb_mode,
  input  logic [9:0]      dev_addr,
  input  logic [CNTW-1:0] rd_count,
  input  logic [DIVW-1:0] div,
  input  logic            tx_avail,
  input  logic [7:0]      tx_data,
  output logic            tx_pop,
  output logic            rx_push,
  output logic [7:0]      rx_data,
  output logic            busy,
  output logic            done,
  output logic            nak_addr,
  output logic            nak_data,
  input  logic            sda_in,
  output logic            scl_lo,
  output logic            sda_lo
);
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BIT, ST_STOP} st_t;
  typedef enum logic [1:0] {K_HDR, K_ADR2, K_TX, K_RX} kind_t;

  st_t             st;
  kind_t           bk;
  logic [DIVW-1:0] cnt;
  logic [3:0]      bitn;
  logic [7:0]      sh;
  logic            ackb, dir, ten, rd_q, comb_q;
  logic [9:0]      addr_q;
  logic [CNTW-1:0] left;
  logic [1:0]      res;

  logic [DIVW:0] per, half, q1, q3, cntx;
  assign per  = {1'b0, div} + 1'b1;
  assign half = per >> 1;
  assign q1   = half >> 1;
  assign q3   = half + ((per - half) >> 1);
  assign cntx = {1'b0, cnt};

  wire at0   = (cnt == '0);
  wire atq1  = (cntx == q1);
  wire ath   = (cntx == half);
  wire atq3  = (cntx == q3);
  wire atend = (cnt == div);

  wire need_rd  = rd_q | comb_q;
  wire more_tx  = (!rd_q || comb_q) && tx_avail;
  wire [7:0] hdr = ten ? {5'b11110, addr_q[9:8], dir} : {addr_q[6:0], dir};
  wire byte_end = (st == ST_BIT) && atend && (bitn == 4'd8);
  wire wr_point = (bk == K_TX) || (bk == K_ADR2) || (bk == K_HDR && !dir && !ten);

  assign tx_pop  = byte_end && !ackb && wr_point && more_tx;
  assign rx_push = byte_end && (bk == K_RX);
  assign rx_data = sh;
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bk <= K_HDR; cnt <= '0; bitn <= '0; sh <= '0;
      ackb <= 1'b0; dir <= 1'b0; ten <= 1'b0; rd_q <= 1'b0; comb_q <= 1'b0;
      addr_q <= '0; left <= '0; res <= '0;
      done <= 1'b0; nak_addr <= 1'b0; nak_data <= 1'b0;
      scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      done <= 1'b0; nak_addr <= 1'b0; nak_data <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          st     <= ST_START;
          cnt    <= '0;
          res    <= 2'd0;
          addr_q <= dev_addr;
          rd_q   <= rd_mode;
          comb_q <= comb_mode;
          left   <= rd_count;
          ten    <= |dev_addr[9:7];
          dir    <= rd_mode && !comb_mode && !(|dev_addr[9:7]);
        end
      end else begin
        cnt <= atend ? '0 : cnt + 1'b1;
        if (at0) scl_lo <= 1'b1;
        if (ath) scl_lo <= 1'b0;
        if (atq1) begin
          case (st)
            ST_START: sda_lo <= 1'b0;
            ST_STOP:  sda_lo <= 1'b1;
            default:  sda_lo <= (bitn != 4'd8) ? (bk != K_RX && !sh[7])
                                               : (bk == K_RX && left != '0);
          endcase
        end
        if (atq3) begin
          case (st)
            ST_START: sda_lo <= 1'b1;
            ST_STOP:  sda_lo <= 1'b0;
            default: begin
              if (bitn == 4'd8) ackb <= sda_in;
              else if (bk == K_RX) sh <= {sh[6:0], sda_in};
            end
          endcase
        end
        if (atend) begin
          case (st)
            ST_START: begin st <= ST_BIT; bk <= K_HDR; sh <= hdr; bitn <= '0; end
            ST_STOP: begin
              st <= ST_IDLE;
              done     <= (res == 2'd0);
              nak_addr <= (res == 2'd1);
              nak_data <= (res == 2'd2);
            end
            default: begin
              if (bitn != 4'd8) begin
                bitn <= bitn + 1'b1;
                if (bk != K_RX) sh <= sh << 1;
              end else begin
                bitn <= '0;
                if (bk == K_RX) begin
                  if (left == '0) st <= ST_STOP;
                  else left <= left - 1'b1;
                end else if (ackb) begin
                  st  <= ST_STOP;
                  res <= (bk == K_TX) ? 2'd2 : 2'd1;
                end else if (bk == K_HDR && dir) begin
                  bk <= K_RX;
                end else if (bk == K_HDR && ten) begin
                  bk <= K_ADR2; sh <= addr_q[7:0];
                end else if (more_tx) begin
                  bk <= K_TX; sh <= tx_data;
                end else if (need_rd) begin
                  st <= ST_START; dir <= 1'b1;
                end else begin
                  st <= ST_STOP;
                end
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_xfer_engine_chk.sv
module i2c_xfer_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       nak_addr,
  input logic       nak_data,
  input logic       scl_lo,
  input logic       sda_lo,
  input logic       tx_pop,
  input logic       tx_avail,
  input logic [1:0] st
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_lo && !sda_lo));

  assert_pop_has_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (tx_avail && busy));

  assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, nak_addr, nak_data}) <= 1);

  assert_result_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || nak_addr || nak_data) |-> (!busy && $past(busy)));

  assert_sda_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_lo && !$past(scl_lo) && (sda_lo != $past(sda_lo))) |->
      ($past(st) == 2'd1 || $past(st) == 2'd3));
endmodule

bind i2c_xfer_engine i2c_xfer_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .nak_addr(nak_addr),
  .nak_data(nak_data), .scl_lo(scl_lo), .sda_lo(sda_lo), .tx_pop(tx_pop),
  .tx_avail(tx_avail), .st(st)
);

// File: tb/i2c_xfer_engine_tb.sv
module i2c_xfer_engine_tb;
  localparam int DIV  = 7;
  localparam int EV_S = 256;
  localparam int EV_P = 512;
  localparam int EV_A = 768;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, rd_mode = 0, comb_mode = 0;
  logic [9:0] dev_addr = '0;
  logic [3:0] rd_count = '0;
  logic [15:0] div = 16'(DIV);
  logic tx_avail, tx_pop, rx_push, busy, done, nak_addr, nak_data, scl_lo, sda_lo;
  logic [7:0] tx_data, rx_data;
  logic s_lo = 0;
  wire scl = !scl_lo;
  wire sda = !(sda_lo || s_lo);

  always #4 clk = !clk;

  logic [7:0] tx_mem [0:31];
  int tx_wp = 0, tx_rp = 0;
  logic tx_flush = 0;
  assign tx_avail = (tx_wp != tx_rp);
  assign tx_data  = tx_mem[tx_rp % 32];
  always @(posedge clk) if (tx_flush) tx_rp <= tx_wp; else if (tx_pop) tx_rp <= tx_rp + 1;

  i2c_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode), .comb_mode(comb_mode),
    .dev_addr(dev_addr), .rd_count(rd_count), .div(div), .tx_avail(tx_avail),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .busy(busy), .done(done), .nak_addr(nak_addr), .nak_data(nak_data),
    .sda_in(sda), .scl_lo(scl_lo), .sda_lo(sda_lo));

  int n_chk = 0, n_fail = 0;
  string tag = "R1";
  int exp_q[$];
  int rx_q[$];

  task automatic chk(input bit ok, input string r, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, expv);
    end
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'hC3 ^ 8'(k * 29);
  endfunction

  task automatic got(input int v);
    int e;
    if (exp_q.size() == 0) begin
      chk(0, {tag, " R12 unexpected bus event"}, v, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e == v, {tag, " R12 bus event"}, v, e);
    end
  endtask

  // target model and scoreboard monitor
  logic ps, pd, rdm, pend;
  int bc, fi, rk, nak_idx = -1, cyc = 0, lastfall = -1, per_bad = 0, per_seen = 0;
  logic [7:0] sb, ob;
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      ps = 1; pd = 1; bc = 0; fi = 0; rk = 0; rdm = 0; pend = 0; s_lo = 0;
    end else begin
      if (ps && scl && pd && !sda) begin
        got(EV_S); bc = 0; fi = 0; rk = 0; rdm = 0; pend = 0; s_lo = 0;
      end else if (ps && scl && !pd && sda) begin
        got(EV_P); rdm = 0; s_lo = 0; bc = 0; lastfall = -1;
      end else if (!ps && scl) begin
        if (bc < 8) begin
          if (!rdm) sb = {sb[6:0], sda};
        end else if (bc == 8 && rdm) begin
          got(EV_A | int'(sda));
          if (sda) rdm = 0;
        end
        bc++;
      end else if (ps && !scl) begin
        if (lastfall >= 0) begin
          per_seen++;
          if (cyc - lastfall != DIV + 1) per_bad++;
        end
        lastfall = cyc;
        if (bc == 8) begin
          if (!rdm) begin
            got(int'(sb));
            s_lo = (fi != nak_idx);
            if (fi == 0 && sb[0] && fi != nak_idx) pend = 1;
          end else s_lo = 0;
        end else if (bc == 9) begin
          s_lo = 0; bc = 0; fi++;
          if (pend) begin rdm = 1; pend = 0; end
          if (rdm) begin ob = pat(rk); rk++; s_lo = !ob[7]; end
        end else if (rdm && bc > 0 && bc < 8) begin
          s_lo = !ob[7 - bc];
        end
      end
      ps = scl; pd = sda;
    end
  end

  always @(negedge clk) begin
    if (rst_n && rx_push) begin
      if (rx_q.size() == 0) chk(0, "R6 unexpected rx byte", int'(rx_data), -1);
      else begin
        int e;
        e = rx_q.pop_front();
        chk(int'(rx_data) == e, "R6 rx byte", int'(rx_data), e);
      end
    end
  end

  task automatic put_tx(input logic [7:0] b);
    tx_mem[tx_wp % 32] = b;
    tx_wp++;
  endtask

  task automatic go(input bit rd, input bit cb, input logic [9:0] a, input logic [3:0] n);
    @(negedge clk);
    rd_mode = rd; comb_mode = cb; dev_addr = a; rd_count = n; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_res(output logic [2:0] r);
    int t;
    t = 0; r = 3'b000;
    while (t < 4000) begin
      @(negedge clk);
      if (done || nak_addr || nak_data) begin
        r = {done, nak_addr, nak_data};
        chk(!busy, "R10 busy low at result", int'(busy), 0);
        break;
      end
      t++;
    end
  endtask

  task automatic finish_txn(input logic [2:0] expr, input string r);
    logic [2:0] got_r;
    wait_res(got_r);
    chk(got_r == expr, r, int'(got_r), int'(expr));
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, {r, " all bus events seen"}, exp_q.size(), 0);
    chk(rx_q.size() == 0, {r, " all rx bytes seen"}, rx_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!busy && scl && sda, "R1 idle after reset", {busy, scl, sda}, 3'b011);
    chk(!(done || nak_addr || nak_data), "R1 no result after reset", {done, nak_addr, nak_data}, 0);

    // R5 R3 R2: 7-bit write of three bytes
    tag = "R5";
    put_tx(8'h81); put_tx(8'h00); put_tx(8'hFF);
    exp_q = '{EV_S, 8'h74, 8'h81, 8'h00, 8'hFF, EV_P};
    go(0, 0, 10'h03A, 0);
    finish_txn(3'b100, "R5 write done");
    chk(tx_wp == tx_rp, "R5 queue drained", tx_wp - tx_rp, 0);
    chk(per_bad == 0 && per_seen > 20, "R2 scl period", per_bad, 0);

    // R6 R3: 7-bit read of three bytes
    tag = "R6";
    exp_q = '{EV_S, 8'hA3, EV_A, EV_A, EV_A | 1, EV_P};
    rx_q = '{int'(pat(0)), int'(pat(1)), int'(pat(2))};
    go(1, 0, 10'h051, 2);
    finish_txn(3'b100, "R6 read done");

    // R4: 10-bit write
    tag = "R4";
    put_tx(8'h99);
    exp_q = '{EV_S, 8'hF4, 8'hC5, 8'h99, EV_P};
    go(0, 0, 10'h2C5, 0);
    finish_txn(3'b100, "R4 10-bit write done");

    // R4: 10-bit read with repeated start
    exp_q = '{EV_S, 8'hF4, 8'hC5, EV_S, 8'hF5, EV_A, EV_A | 1, EV_P};
    rx_q = '{int'(pat(0)), int'(pat(1))};
    go(1, 0, 10'h2C5, 1);
    finish_txn(3'b100, "R4 10-bit read done");

    // R7: combined write then read
    tag = "R7";
    put_tx(8'h10);
    exp_q = '{EV_S, 8'h44, 8'h10, EV_S, 8'h45, EV_A, EV_A | 1, EV_P};
    rx_q = '{int'(pat(0)), int'(pat(1))};
    go(0, 1, 10'h022, 1);
    finish_txn(3'b100, "R7 combined done");

    // R8: address not acknowledged
    tag = "R8";
    nak_idx = 0;
    put_tx(8'h12); put_tx(8'h34);
    exp_q = '{EV_S, 8'h66, EV_P};
    go(0, 0, 10'h033, 0);
    finish_txn(3'b010, "R8 address nak");
    chk(tx_wp - tx_rp == 2, "R8 no data popped", tx_wp - tx_rp, 2);
    @(negedge clk); tx_flush = 1; @(negedge clk); tx_flush = 0;

    // R9: second data byte not acknowledged
    tag = "R9";
    nak_idx = 2;
    put_tx(8'hA1); put_tx(8'hB2); put_tx(8'hC3);
    exp_q = '{EV_S, 8'h20, 8'hA1, 8'hB2, EV_P};
    go(0, 0, 10'h010, 0);
    finish_txn(3'b001, "R9 data nak");
    chk(tx_wp - tx_rp == 1, "R9 rest left queued", tx_wp - tx_rp, 1);
    @(negedge clk); tx_flush = 1; @(negedge clk); tx_flush = 0;
    nak_idx = -1;

    // R11: start ignored while busy, accepted in the result cycle
    tag = "R11";
    put_tx(8'h5A);
    exp_q = '{EV_S, 8'h22, 8'h5A, EV_P, EV_S, 8'h23, EV_A | 1, EV_P};
    rx_q = '{int'(pat(0))};
    go(0, 0, 10'h011, 0);
    repeat (40) @(negedge clk);
    chk(busy, "R11 busy mid transaction", int'(busy), 1);
    rd_mode = 1; dev_addr = 10'h055; start = 1;
    @(negedge clk);
    start = 0;
    wait_res(r);
    chk(r == 3'b100, "R11 first done", int'(r), 4);
    rd_mode = 1; comb_mode = 0; dev_addr = 10'h011; rd_count = 0; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy, "R11 accepted in result cycle", int'(busy), 1);
    finish_txn(3'b100, "R11 second done");
    chk(scl && sda, "R1 released after run", {scl, sda}, 3);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule